// File: doc/BRIEF.md
# CAN Bit Timing Generator and Receive Sampler

This block divides each CAN bit into a one-quantum sync segment, a programmable first segment and a programmable second segment. It counts time quanta from a supplied time-quantum enable and samples the receive line once per bit. A pulse at the sample point, a pulse at the end of the bit and the sampled bit value are its outputs. The baud prescaler, edge resynchronisation and frame logic sit outside it.

An 8-bit timing register sets both segment lengths and picks one of two sampling modes. In single mode the line is taken once, at the sample point. In triple mode the last three quanta up to and including the sample point are combined by majority vote, which filters short spikes. The register can be written and read back only while the hold (reset-request) input is high. While hold is high the bit counter is parked in the sync segment and no strobes are produced. The first quantum after hold falls starts a new bit.

Top module: `can_bit_timer`

## Requirements
- R1: While `hold` is high, a cycle with `cfg_we` high loads `cfg_wdata` into the timing register, and `cfg_rdata` returns it. Field positions: bit 7 selects triple sampling (1) or single sampling (0), bits 6:4 hold the segment-2 field S2 and bits 3:0 hold the segment-1 field S1.
- R2: While `hold` is low, `cfg_we` has no effect on the register and `cfg_rdata` reads 0.
- R3: A bit lasts 3 + S1 + S2 quanta, with quantum indices 0 to S1+S2+2 that wrap to 0. `bit_end_stb` is high for one cycle, on the cycle after the enabled cycle of the last quantum.
- R4: `sample_stb` is high for one cycle, on the cycle after the enabled cycle of quantum index S1+1 (the last quantum of segment 1).
- R5: In single mode, `rx_bit` takes the value of `rx_in` in the sample quantum. It changes only together with `sample_stb`.
- R6: In triple mode, `rx_bit` becomes the majority of `rx_in` in quanta S1-1, S1 and S1+1.
- R7: Timing advances only on cycles with `tq_en` high. On the cycle after a cycle with `tq_en` low, both strobes are low.
- R8: While `hold` is high, the counter stays at quantum 0 and no strobes are produced. The first enabled quantum after `hold` falls is quantum 0 of a new bit.
- R9: After reset the timing register is 0, both strobes are low and `rx_bit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tq_en | input | 1 | One-cycle time-quantum enable |
| hold | input | 1 | Reset request: unlocks the register and freezes timing |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 8 | Timing register write data |
| cfg_rdata | output | 8 | Timing register read data (0 while hold is low) |
| rx_in | input | 1 | Receive line |
| sample_stb | output | 1 | Sample-point pulse |
| bit_end_stb | output | 1 | End-of-bit pulse |
| rx_bit | output | 1 | Sampled bit value |

## Verification
A wrong quantum count shows up within one bit: `sample_stb` or `bit_end_stb` appears one or more enabled quanta away from the index the register fields predict. A counter that fails to wrap shows up on the second of two back-to-back bits. A fault in the vote history corrupts `rx_bit` at the next sample point, and only for patterns where a spike disagrees with its neighbours, so the bench drives isolated spikes in both polarities. A leak through the register lock shows up at the next read-back under hold.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int TS1_W   = 4;
  localparam int TS2_W   = 3;
  localparam int CFG_W   = 1 + TS2_W + TS1_W;
  localparam int BIT_MAX = (1 << TS1_W) + (1 << TS2_W) + 1;
  localparam int CNT_W   = $clog2(BIT_MAX);
  localparam int VOTE_N  = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  // The bit order follows the register layout: mode, segment 2, segment 1.
  typedef struct packed {
    logic             triple;
    logic [TS2_W-1:0] seg2;
    logic [TS1_W-1:0] seg1;
  } cfg_t;

  // Index of the final quantum of a bit: sync + (seg1+1) + (seg2+1) - 1.
  function automatic cnt_t bit_last(input logic [TS1_W-1:0] s1,
                                    input logic [TS2_W-1:0] s2);
    return cnt_t'(s1) + cnt_t'(s2) + cnt_t'(2);
  endfunction

  // The sample point is the last quantum of segment 1.
  function automatic cnt_t samp_idx(input logic [TS1_W-1:0] s1);
    return cnt_t'(s1) + cnt_t'(1);
  endfunction

  function automatic logic majority(input logic [VOTE_N-1:0] w);
    int n;
    n = 0;
    for (int i = 0; i < VOTE_N; i++) n += int'(w[i]);
    return n > VOTE_N / 2;
  endfunction
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter cfg_t RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfg_q <= RST_VAL;
    else if (hold && we)  cfg_q <= cfg_t'(wdata);
  end

  assign rdata = hold ? CFG_W'(cfg_q) : '0;
  assign cfg   = cfg_q;

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> $stable(cfg_q));
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tq_en,
  input  cfg_t cfg,
  output cnt_t q_cnt,
  output logic samp_pt,
  output logic end_pt
);
  cnt_t last_q;
  cnt_t samp_q;
  logic run;

  assign last_q  = bit_last(cfg.seg1, cfg.seg2);
  assign samp_q  = samp_idx(cfg.seg1);
  assign run     = tq_en && !hold;
  assign samp_pt = run && (q_cnt == samp_q);
  assign end_pt  = run && (q_cnt == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_cnt <= '0;
    else if (hold)   q_cnt <= '0;
    else if (tq_en)  q_cnt <= (q_cnt == last_q) ? '0 : q_cnt + cnt_t'(1);
  end

  // R7
  no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tq_en && !hold) |=> $stable(q_cnt));
  // R8
  hold_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (q_cnt == '0));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= last_q);
endmodule

// File: rtl/can_bt_vote.sv
module can_bt_vote
  import can_bt_pkg::*;
#(
  parameter int N = VOTE_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tq_en,
  input  logic rx_in,
  input  logic triple,
  input  logic samp_pt,
  output logic rx_bit
);
  localparam int HIST_W = N - 1;

  logic [HIST_W-1:0] hist;
  logic [N-1:0]      win;
  logic              pick;

  assign win  = {hist, rx_in};
  assign pick = triple ? majority(win) : rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hist <= '0;
    else if (tq_en && !hold)  hist <= win[HIST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_bit <= 1'b1;
    else if (samp_pt)  rx_bit <= pick;
  end

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_pt |=> $stable(rx_bit));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             hold,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             rx_in,
  output logic             sample_stb,
  output logic             bit_end_stb,
  output logic             rx_bit
);
  cfg_t cfg;
  cnt_t q_cnt;
  logic samp_pt;
  logic end_pt;

  can_bt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(cfg_we),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  can_bt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tq_en(tq_en), .cfg(cfg),
    .q_cnt(q_cnt), .samp_pt(samp_pt), .end_pt(end_pt)
  );

  can_bt_vote u_vote (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tq_en(tq_en), .rx_in(rx_in),
    .triple(cfg.triple), .samp_pt(samp_pt), .rx_bit(rx_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_stb  <= 1'b0;
      bit_end_stb <= 1'b0;
    end else begin
      sample_stb  <= samp_pt;
      bit_end_stb <= end_pt;
    end
  end

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!sample_stb && !bit_end_stb));
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, bit_end_stb}));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tq_en |=> (!sample_stb && !bit_end_stb));
endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tq_en = 1'b0;
  logic       hold = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       rx_in = 1'b1;
  logic       sample_stb;
  logic       bit_end_stb;
  logic       rx_bit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .hold(hold),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_in(rx_in), .sample_stb(sample_stb), .bit_end_stb(bit_end_stb),
    .rx_bit(rx_bit)
  );

  typedef struct packed {
    logic [7:0]  cfg;
    logic [31:0] pat;   // rx_in per quantum index, bit i = quantum i
    logic [7:0]  len;
    logic [7:0]  sp;
    logic        exp_bit;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'h0000_0002, 8'd3,  8'd1,  1'b1},
    '{8'h23, 32'h0000_00EF, 8'd8,  8'd4,  1'b0},
    '{8'hA3, 32'h0000_0014, 8'd8,  8'd4,  1'b1},
    '{8'hA3, 32'h0000_00EB, 8'd8,  8'd4,  1'b0},
    '{8'h7F, 32'h0001_0000, 8'd25, 8'd16, 1'b1},
    '{8'hF1, 32'h0000_0003, 8'd11, 8'd2,  1'b1},
    '{8'h81, 32'h0000_0006, 8'd4,  8'd2,  1'b1},
    '{8'h01, 32'h0000_0003, 8'd4,  8'd2,  1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    hold = 1'b1; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One enabled quantum followed by one idle cycle; outputs checked after each.
  task automatic quantum(input logic rx, output logic s, output logic e, output logic b);
    tq_en = 1'b1; rx_in = rx;
    @(negedge clk);
    s = sample_stb; e = bit_end_stb; b = rx_bit;
    tq_en = 1'b0;
    @(negedge clk);
    chk(!sample_stb && !bit_end_stb, "R7", {sample_stb, bit_end_stb}, 0);
  endtask

  task automatic run_bit(input vec_t v, input string tag);
    logic s, e, b;
    for (int q = 0; q < int'(v.len); q++) begin
      quantum(v.pat[q], s, e, b);
      chk(s == (q == int'(v.sp)), {"R4 ", tag}, s, q == int'(v.sp));
      chk(e == (q == int'(v.len) - 1), {"R3 ", tag}, e, q == int'(v.len) - 1);
      if (q == int'(v.sp))
        chk(b == v.exp_bit, v.cfg[7] ? {"R6 ", tag} : {"R5 ", tag}, b, v.exp_bit);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s, e, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!sample_stb && !bit_end_stb, "R9 strobes", {sample_stb, bit_end_stb}, 0);
    chk(rx_bit == 1'b1, "R9 rx_bit", rx_bit, 1);
    chk(cfg_rdata == 8'h00, "R2 read while unlocked", cfg_rdata, 0);
    hold = 1'b1;
    #1;
    chk(cfg_rdata == 8'h00, "R9 cfg", cfg_rdata, 0);

    // Table walk: two back-to-back bits per vector to cover the wrap.
    for (int i = 0; i < NV; i++) begin
      write_cfg(VECS[i].cfg);
      chk(cfg_rdata == VECS[i].cfg, "R1 readback", cfg_rdata, VECS[i].cfg);
      hold = 1'b0;
      @(negedge clk);
      run_bit(VECS[i], "first");
      run_bit(VECS[i], "second");
    end

    // R2: a write while unlocked is ignored
    write_cfg(8'h23);
    hold = 1'b0;
    cfg_we = 1'b1; cfg_wdata = 8'h55;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == 8'h00, "R2 read while unlocked", cfg_rdata, 0);
    hold = 1'b1;
    #1;
    chk(cfg_rdata == 8'h23, "R2 ignored write", cfg_rdata, 8'h23);

    // R8: quanta under hold produce no strobes
    for (int k = 0; k < 30; k++) begin
      tq_en = 1'b1;
      @(negedge clk);
      chk(!sample_stb && !bit_end_stb, "R8 hold quiet", {sample_stb, bit_end_stb}, 0);
    end
    tq_en = 1'b0;

    // R8: hold mid-bit, then release restarts at the sync quantum
    hold = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) quantum(1'b1, s, e, b);
    hold = 1'b1;
    tq_en = 1'b1;
    @(negedge clk);
    chk(!sample_stb && !bit_end_stb, "R8 hold mid-bit", {sample_stb, bit_end_stb}, 0);
    tq_en = 1'b0;
    hold = 1'b0;
    @(negedge clk);
    run_bit('{8'h23, 32'h0000_00EF, 8'd8, 8'd4, 1'b0}, "R8 restart");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule